// File: doc/BRIEF.md
# Data EEPROM Controller with Write Unlock

This block sits on a simple processor register bus and manages a small byte-wide nonvolatile data store, modelled here as an array of internal registers. Software sees four registers: an address register, a data register, a control register and a write-only key register. Setting the read bit in the control register copies the addressed byte into the data register in a single clock, so the result can be read on the very next bus cycle.

A write is deliberately hard to start by accident. Software loads the address and the data. It writes two key bytes in a fixed order to the key register and then, on the very next bus write, sets the write-start bit. The enable bit must already be set when the start bit is written. The write then runs for a parameterised number of clocks, with the address and data captured at the start. When the write ends, the busy bit drops and a sticky completion flag rises. That flag is also driven to a pin for an interrupt controller.

Register select codes are 0 address, 1 data, 2 control and 3 key. The control register has these bits: bit 7 selects the program store (1) or the data store (0), bit 4 is the completion flag, bit 2 is the write enable, bit 1 is the write start and busy bit, and bit 0 is the read start bit, which always reads back as 0.

Top module: `nvm_data_ctrl`

## Requirements
- R1: After reset the address, data and control registers read 0, busy and the completion flag are 0, and every array byte holds FFh.
- R2: A control write (select 2) with bit 0 at 1, bit 7 at 0 and no write busy loads the array byte at the address register into the data register (select 1). The byte is readable in the next clock cycle.
- R3: The data register keeps its value until the next read or until a bus write to select 1.
- R4: A read request is ignored while a write is busy, and also when bit 7 of the same control write is 1.
- R5: A write starts only on a control write with bit 1 at 1 and bit 7 at 0 that immediately follows a write of 55h and then AAh to the key register (select 3), and only if the enable bit (control bit 2) was already 1 before that control write.
- R6: A wrong key value, a key byte out of order, or any write to another register between the steps voids the sequence. Each write needs a fresh sequence.
- R7: Busy (control bit 1, pin `wr_busy`) stays high for exactly WRITE_CYCLES clocks. At the end, the array byte at the address captured at the start takes the data captured at the start, even if the address or data registers were rewritten in the meantime.
- R8: On the clock where busy drops, the completion flag (control bit 4, pin `wr_done_flag`) rises.
- R9: The completion flag is cleared only by a control write with bit 4 at 0. A control write with bit 4 at 1 leaves it unchanged.
- R10: Hardware never changes the enable bit. Clearing it while a write is busy does not stop or alter that write.
- R11: Reads of the key register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| bus_we | input | 1 | Register write strobe for one clock |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data of the selected register, combinational |
| wr_busy | output | 1 | Write in progress |
| wr_done_flag | output | 1 | Sticky completion flag |

## Verification
The write path is driven with a correct unlock sequence, and also with sequences that differ in one way each: the enable bit missing, an extra register write between the keys, the keys swapped, a wrong second key, the program-store bit set, and a second start with no new keys. This separates an unlock detector that tracks exact order from one that only looks for matching values. Reads are tried on a fresh array, after a write, while a write is busy and with the program-store bit set, so stale data, lost reads and reads that should have been blocked show up separately. During a busy write the address register is rewritten and the enable bit is cleared, which shows whether the write uses captured or live values. A reference model steps alongside the design on every clock and compares busy, the flag and whichever register is selected.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_KEY  = 2'd3
   } nvm_sel_e;

   typedef enum logic [1:0] {
      UL_IDLE  = 2'd0,
      UL_HALF  = 2'd1,
      UL_ARMED = 2'd2
   } unlock_st_e;

   // control register bit positions
   localparam int unsigned CB_RD   = 0;
   localparam int unsigned CB_WR   = 1;
   localparam int unsigned CB_WREN = 2;
   localparam int unsigned CB_DONE = 4;
   localparam int unsigned CB_PSEL = 7;

endpackage

// File: rtl/nvm_unlock_seq.sv
module nvm_unlock_seq
   import nvm_ctrl_pkg::*;
#(
   parameter int unsigned   DW    = 8,
   parameter logic [DW-1:0] KEY_A = DW'(8'h55),
   parameter logic [DW-1:0] KEY_B = DW'(8'hAA)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic          key_sel,
   input  logic [DW-1:0] wdata,
   output logic          armed
);

   unlock_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (bus_we) begin
         if (key_sel) begin
            unique case (st_q)
               UL_IDLE: st_d = (wdata == KEY_A) ? UL_HALF  : UL_IDLE;
               UL_HALF: st_d = (wdata == KEY_B) ? UL_ARMED : UL_IDLE;
               default: st_d = UL_IDLE;
            endcase
         end else begin
            // any other register write consumes or voids the sequence
            st_d = UL_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= UL_IDLE;
      else        st_q <= st_d;
   end

   assign armed = (st_q == UL_ARMED);

endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   localparam int unsigned CW = $clog2(CYCLES + 1);

   generate
      if (CYCLES == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= start;
         end
         assign busy = busy_q;
         assign done = busy_q;
      end else begin : g_count
         logic          busy_q;
         logic [CW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               left_q <= '0;
            end else if (start) begin
               busy_q <= 1'b1;
               left_q <= CW'(CYCLES);
            end else if (busy_q) begin
               left_q <= left_q - 1'b1;
               if (left_q == CW'(1)) busy_q <= 1'b0;
            end
         end
         assign busy = busy_q;
         assign done = busy_q && (left_q == CW'(1));
      end
   endgenerate

endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
   parameter int unsigned   DEPTH      = 256,
   parameter int unsigned   DW         = 8,
   parameter logic [DW-1:0] INIT_VALUE = DW'(8'hFF),
   localparam int unsigned  AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd
);

   logic [DW-1:0] mem [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     mem[i] <= INIT_VALUE;
            else if (we && (wa == AW'(i)))  mem[i] <= wd;
         end
      end
   endgenerate

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nvm_data_ctrl.sv
module nvm_data_ctrl
   import nvm_ctrl_pkg::*;
#(
   parameter int unsigned   DEPTH        = 256,
   parameter int unsigned   DW           = 8,
   parameter int unsigned   WRITE_CYCLES = 16,
   parameter logic [DW-1:0] INIT_VALUE   = DW'(8'hFF),
   parameter logic [DW-1:0] KEY_A        = DW'(8'h55),
   parameter logic [DW-1:0] KEY_B        = DW'(8'hAA)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    bus_sel,
   input  logic          bus_we,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          wr_busy,
   output logic          wr_done_flag
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   // elaboration-time parameter checks
   generate
      if (DW < 8) begin : g_bad_dw
         $error("nvm_data_ctrl: DW must be at least 8");
      end
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("nvm_data_ctrl: DEPTH must be a power of two, at least 2");
      end
      if (AW > DW) begin : g_bad_aw
         $error("nvm_data_ctrl: address does not fit the data width");
      end
      if (WRITE_CYCLES < 1) begin : g_bad_cyc
         $error("nvm_data_ctrl: WRITE_CYCLES must be at least 1");
      end
      if (KEY_A == KEY_B) begin : g_bad_key
         $error("nvm_data_ctrl: the two key bytes must differ");
      end
   endgenerate

   logic          addr_we, data_we, ctrl_we, key_we;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          psel_q, wren_q, flag_q;
   logic [AW-1:0] lat_addr_q;
   logic [DW-1:0] lat_data_q;
   logic          armed, wr_fire, rd_fire, wr_end;
   logic [DW-1:0] arr_rd;
   logic [DW-1:0] ctrl_view;

   assign addr_we = bus_we && (bus_sel == SEL_ADDR);
   assign data_we = bus_we && (bus_sel == SEL_DATA);
   assign ctrl_we = bus_we && (bus_sel == SEL_CTRL);
   assign key_we  = bus_we && (bus_sel == SEL_KEY);

   nvm_unlock_seq #(
      .DW    (DW),
      .KEY_A (KEY_A),
      .KEY_B (KEY_B)
   ) u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_we  (bus_we),
      .key_sel (key_we),
      .wdata   (bus_wdata),
      .armed   (armed)
   );

   // start qualification uses the enable bit held before this write
   assign wr_fire = ctrl_we && bus_wdata[CB_WR] && !bus_wdata[CB_PSEL]
                    && wren_q && armed && !wr_busy;
   assign rd_fire = ctrl_we && bus_wdata[CB_RD] && !bus_wdata[CB_PSEL]
                    && !wr_busy && !wr_fire;

   nvm_write_timer #(
      .CYCLES (WRITE_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_fire),
      .busy  (wr_busy),
      .done  (wr_end)
   );

   nvm_array #(
      .DEPTH      (DEPTH),
      .DW         (DW),
      .INIT_VALUE (INIT_VALUE)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (addr_q),
      .rd_data (arr_rd),
      .we      (wr_end),
      .wa      (lat_addr_q),
      .wd      (lat_data_q)
   );

   // address register, truncated to the array index width
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (addr_we) addr_q <= bus_wdata[AW-1:0];
   end

   // data register: bus write or array read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (data_we) data_q <= bus_wdata;
      else if (rd_fire) data_q <= arr_rd;
   end

   // control bits owned by software
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psel_q <= 1'b0;
         wren_q <= 1'b0;
      end else if (ctrl_we) begin
         psel_q <= bus_wdata[CB_PSEL];
         wren_q <= bus_wdata[CB_WREN];
      end
   end

   // completion flag: hardware sets, software clears with a 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         if (ctrl_we) flag_q <= flag_q & bus_wdata[CB_DONE];
         if (wr_end)  flag_q <= 1'b1;
      end
   end

   // write operands captured at start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_addr_q <= '0;
         lat_data_q <= '0;
      end else if (wr_fire) begin
         lat_addr_q <= addr_q;
         lat_data_q <= data_q;
      end
   end

   always_comb begin
      ctrl_view          = '0;
      ctrl_view[CB_PSEL] = psel_q;
      ctrl_view[CB_DONE] = flag_q;
      ctrl_view[CB_WREN] = wren_q;
      ctrl_view[CB_WR]   = wr_busy;
   end

   always_comb begin
      unique case (bus_sel)
         SEL_ADDR: bus_rdata = DW'(addr_q);
         SEL_DATA: bus_rdata = data_q;
         SEL_CTRL: bus_rdata = ctrl_view;
         default:  bus_rdata = '0;
      endcase
   end

   assign wr_done_flag = flag_q;

endmodule

// File: rtl/nvm_data_ctrl_chk.sv
module nvm_data_ctrl_chk #(
   parameter int unsigned   DW           = 8,
   parameter int unsigned   WRITE_CYCLES = 16,
   parameter logic [DW-1:0] KEY_B        = DW'(8'hAA)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    bus_sel,
   input logic          bus_we,
   input logic [DW-1:0] bus_wdata,
   input logic [DW-1:0] bus_rdata,
   input logic          wr_busy,
   input logic          wr_done_flag,
   input logic          wren_q,
   input logic          armed
);

   int unsigned busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_len <= 0;
      else if (wr_busy) busy_len <= busy_len + 1;
      else              busy_len <= 0;
   end

   // R5: start needs the enable bit held beforehand
   a_r5_start_needs_wren: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> $past(wren_q));

   // R5: start only from an armed control write with bit 1
   a_r5_start_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> $past(bus_we && bus_sel == 2'd2 && bus_wdata[1] && armed));

   // R6: arming only by the second key byte
   a_r6_arm_on_second_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(bus_we && bus_sel == 2'd3 && bus_wdata == KEY_B));

   // R7: busy window length
   a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_busy) |-> (busy_len == WRITE_CYCLES));

   // R8: flag raised when busy ends
   a_r8_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_busy) |-> wr_done_flag);

   // R9: flag falls only on a software clear
   a_r9_flag_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_done_flag) |-> $past(bus_we && bus_sel == 2'd2 && !bus_wdata[4]));

   // R10: enable bit falls only on a software write
   a_r10_wren_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wren_q) |-> $past(bus_we && bus_sel == 2'd2 && !bus_wdata[2]));

   // R11: key register reads zero
   a_r11_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel == 2'd3) |-> (bus_rdata == '0));

endmodule

bind nvm_data_ctrl nvm_data_ctrl_chk #(
   .DW           (DW),
   .WRITE_CYCLES (WRITE_CYCLES),
   .KEY_B        (KEY_B)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_sel      (bus_sel),
   .bus_we       (bus_we),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .wr_busy      (wr_busy),
   .wr_done_flag (wr_done_flag),
   .wren_q       (wren_q),
   .armed        (armed)
);

// File: tb/sim_nvm_data_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_data_ctrl;

   localparam int WC = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       wr_busy, wr_done_flag;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   nvm_data_ctrl #(.WRITE_CYCLES(WC)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wr_busy(wr_busy), .wr_done_flag(wr_done_flag)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [7:0] m_mem [256];
   logic [7:0] m_addr, m_data, m_la, m_ld;
   logic       m_psel, m_wren, m_flag, m_busy;
   int         m_left, m_stage;
   logic       m_fin, m_old_wren, m_old_busy;

   task automatic model_reset();
      for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
      m_addr = 0; m_data = 0; m_la = 0; m_ld = 0;
      m_psel = 0; m_wren = 0; m_flag = 0; m_busy = 0;
      m_left = 0; m_stage = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         m_fin = 1'b0;
         m_old_wren = m_wren;
         m_old_busy = m_busy;
         if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
               m_mem[m_la] = m_ld;
               m_busy = 1'b0;
               m_fin = 1'b1;
            end
         end
         if (bus_we) begin
            if (bus_sel == 2'd3) begin
               if (m_stage == 0 && bus_wdata == 8'h55)      m_stage = 1;
               else if (m_stage == 1 && bus_wdata == 8'hAA) m_stage = 2;
               else                                         m_stage = 0;
            end else begin
               if (bus_sel == 2'd0)      m_addr = bus_wdata;
               else if (bus_sel == 2'd1) m_data = bus_wdata;
               else begin
                  m_psel = bus_wdata[7];
                  m_wren = bus_wdata[2];
                  if (!bus_wdata[4]) m_flag = 1'b0;
                  if (bus_wdata[1] && !bus_wdata[7] && m_old_wren && m_stage == 2 && !m_old_busy) begin
                     m_busy = 1'b1; m_left = WC; m_la = m_addr; m_ld = m_data;
                  end else if (bus_wdata[0] && !bus_wdata[7] && !m_old_busy) begin
                     m_data = m_mem[m_addr];
                  end
               end
               m_stage = 0;
            end
         end
         if (m_fin) m_flag = 1'b1;
      end
   end

   function automatic logic [7:0] model_rdata(input logic [1:0] s);
      case (s)
         2'd0:    return m_addr;
         2'd1:    return m_data;
         2'd2:    return {m_psel, 2'b00, m_flag, 1'b0, m_wren, m_busy, 1'b0};
         default: return 8'h00;
      endcase
   endfunction

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R7 model busy", {7'd0, wr_busy}, {7'd0, m_busy});
         check("R8 model flag", {7'd0, wr_done_flag}, {7'd0, m_flag});
         check("R3 model readback", bus_rdata, model_rdata(bus_sel));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [1:0] s, input logic [7:0] v);
      @(posedge clk); #2;
      bus_sel = s; bus_we = 1'b1; bus_wdata = v;
      @(posedge clk); #2;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      @(posedge clk); #2;
      bus_sel = s; bus_we = 1'b0;
      @(negedge clk);
      v = bus_rdata;
   endtask

   // read sampled in the cycle right after the read request edge
   task automatic do_read(input logic [7:0] a, input logic [7:0] ctl, output logic [7:0] v);
      wr(2'd0, a);
      wr(2'd2, ctl);
      bus_sel = 2'd1;
      @(negedge clk);
      v = bus_rdata;
   endtask

   task automatic unlock_start(input logic [7:0] ctl);
      wr(2'd3, 8'h55);
      wr(2'd3, 8'hAA);
      wr(2'd2, ctl);
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      forever begin
         @(negedge clk);
         if (wr_busy) n++;
         else break;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      int n;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      rd(2'd2, v); check("R1 ctrl reset", v, 8'h00);
      rd(2'd0, v); check("R1 addr reset", v, 8'h00);
      rd(2'd1, v); check("R1 data reset", v, 8'h00);
      check("R1 flag reset", {7'd0, wr_done_flag}, 8'h00);

      // R1 R2 read of a fresh byte, next-cycle visibility
      do_read(8'h05, 8'h01, v); check("R2 read fresh byte", v, 8'hFF);
      rd(2'd2, v); check("R2 read bit self clears", v, 8'h00);

      // R7 R8 normal write
      wr(2'd0, 8'h10); wr(2'd1, 8'h3C); wr(2'd2, 8'h04);
      unlock_start(8'h06);
      wait_idle(n); check("R7 busy length", 8'(n), 8'(WC));
      check("R8 flag after write", {7'd0, wr_done_flag}, 8'h01);
      rd(2'd2, v); check("R10 wren kept after write", v, 8'h14);
      do_read(8'h10, 8'h14 | 8'h01, v); check("R7 written byte", v, 8'h3C);

      // R9 flag clear rules
      wr(2'd2, 8'h14); check("R9 write 1 keeps flag", {7'd0, wr_done_flag}, 8'h01);
      wr(2'd2, 8'h04); check("R9 write 0 clears flag", {7'd0, wr_done_flag}, 8'h00);

      // R5 enable not already set
      wr(2'd2, 8'h00);
      unlock_start(8'h06);
      check("R5 no start without prior enable", {7'd0, wr_busy}, 8'h00);
      rd(2'd2, v); check("R5 ctrl after refused start", v, 8'h04);

      // R6 broken sequences
      wr(2'd0, 8'h20); wr(2'd1, 8'h77);
      wr(2'd3, 8'h55); wr(2'd1, 8'h77); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
      check("R6 other write between keys", {7'd0, wr_busy}, 8'h00);
      wr(2'd3, 8'hAA); wr(2'd3, 8'h55); wr(2'd2, 8'h06);
      check("R6 keys swapped", {7'd0, wr_busy}, 8'h00);
      wr(2'd3, 8'h55); wr(2'd3, 8'h56); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
      check("R6 wrong second key", {7'd0, wr_busy}, 8'h00);
      unlock_start(8'h86);
      check("R5 program select blocks start", {7'd0, wr_busy}, 8'h00);
      wr(2'd2, 8'h04);
      do_read(8'h20, 8'h05, v); check("R6 byte untouched", v, 8'hFF);

      // R6 fresh sequence per byte
      wr(2'd1, 8'h77);
      unlock_start(8'h06);
      wait_idle(n);
      wr(2'd2, 8'h06);
      check("R6 second start without keys", {7'd0, wr_busy}, 8'h00);
      do_read(8'h20, 8'h05, v); check("R6 first write landed", v, 8'h77);

      // R10 R4 R7 changes during a busy write
      wr(2'd0, 8'h30); wr(2'd1, 8'h5A); wr(2'd2, 8'h04);
      unlock_start(8'h06);
      wr(2'd2, 8'h00);
      check("R10 clear enable keeps busy", {7'd0, wr_busy}, 8'h01);
      wr(2'd0, 8'h10);
      wr(2'd2, 8'h01);
      rd(2'd1, v); check("R4 read ignored while busy", v, 8'h5A);
      wait_idle(n); check("R10 write ran full length", 8'(n > 0), 8'h01);
      rd(2'd2, v); check("R10 enable stays cleared", v, 8'h10);
      do_read(8'h30, 8'h11, v); check("R7 captured data stored", v, 8'h5A);
      do_read(8'h10, 8'h11, v); check("R7 captured address used", v, 8'h3C);

      // R4 program select blocks read
      wr(2'd0, 8'h30); wr(2'd1, 8'h99); wr(2'd2, 8'h81);
      rd(2'd1, v); check("R4 read with program select", v, 8'h99);
      rd(2'd2, v); check("R9 ctrl after clear", v, 8'h80);

      // R3 hold and overwrite
      repeat (5) @(posedge clk);
      rd(2'd1, v); check("R3 data held", v, 8'h99);
      do_read(8'h30, 8'h01, v); check("R3 new read replaces", v, 8'h5A);
      wr(2'd1, 8'h42);
      rd(2'd1, v); check("R3 bus write replaces", v, 8'h42);

      // R11 key register reads zero
      wr(2'd3, 8'h55);
      rd(2'd3, v); check("R11 key reads zero", v, 8'h00);

      repeat (2) @(posedge clk);
      summary();
      $finish;
   end

endmodule